// File: doc/BRIEF.md
# Overlay Line Window Address Generator

This block decides, for each scan line of a panel, whether the line falls inside the window of one of three on-screen overlay images. Each overlay is described by three 9-bit settings: the panel line where its window begins, and the first and last display-RAM lines that hold its picture. The window covers as many panel lines as the RAM range has lines. While a line lies inside a window, the block gives the RAM line to fetch for that overlay. On any other line it reports that the base image is shown.

Software writes the settings through an index/data write port. The display timing logic sends a frame-start strobe and one line strobe per scan line. The block keeps its own line counter. It registers its verdict so that the verdict is valid on the cycle after each strobe. When the drive-mode field selects interlaced drive, the overlay function is turned off.

Top module: `osd_line_addr_gen`

## Requirements
- R1: A write with `wr_en` high stores `wr_data[8:0]` into one setting. Index 0x500+3n holds the window position of overlay n (n = 0, 1, 2), 0x501+3n holds its first RAM line, and 0x502+3n holds its last RAM line. `wr_data[15:9]` is discarded. A write to any other index changes nothing.
- R2: Reset clears all nine settings, the line counter and the outputs to zero.
- R3: A frame strobe sets the line counter to 0. A line strobe adds one to it, wrapping modulo 512. When both strobes arrive in the same cycle, the frame strobe wins.
- R4: Overlay n covers panel lines P through P + (last - first), inclusive. A position of 0 puts the window on the first line of the frame.
- R5: On a covered line L, `ram_line` equals first + (L - P) modulo 512, and `ovl_index` equals n.
- R6: When windows overlap, the overlay with the lowest index is reported.
- R7: An overlay whose last line is below its first line is disabled and covers no line.
- R8: While `drive_mode` equals 2'b11 (interlaced drive), the outputs are forced to zero from the next cycle, so `ovl_active` stays low. The line counter keeps counting during that time. Outputs stay zero until the next strobe after the mode changes.
- R9: The outputs change only on the cycle after a strobe, or on the cycle after interlaced mode is seen, and otherwise hold. Whenever `ovl_active` is low, `ovl_index` and `ram_line` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Setting write enable |
| wr_idx | input | 16 | Setting index |
| wr_data | input | 16 | Setting value; bits [8:0] are used |
| line_stb | input | 1 | Advance to the next scan line |
| frame_stb | input | 1 | Restart at line 0 |
| drive_mode | input | 2 | Drive mode; 2'b11 is interlaced drive |
| ovl_active | output | 1 | Current line shows an overlay |
| ovl_index | output | 2 | Overlay number (0..2) |
| ram_line | output | 9 | Display-RAM line to fetch |

## Verification
The bench probes the first and last line of each window and the lines just outside them. A design that is off by one in the inclusive end compare would show one line too many or too few. A window that ends on the top RAM line, and a window whose position lies near the counter wrap, catch address and width truncation. Overlapping windows and an inverted range check that the lowest index wins and that an inverted overlay stays silent rather than matching a stray line. The bench also covers interlaced mode, where a design that only gated the strobes would leave a stale active flag showing. It covers the case where both strobes arrive together, and writes to indices next to the register block, which a loose decoder would accept.

// File: rtl/osd_win_pkg.sv
package osd_win_pkg;
   localparam int LINE_W         = 9;
   localparam int FIELDS_PER_WIN = 3;

   typedef logic [LINE_W-1:0] line_t;

   typedef struct packed {
      line_t pos;
      line_t first;
      line_t last;
   } win_cfg_t;

   typedef enum logic [1:0] {
      FLD_POS   = 2'd0,
      FLD_FIRST = 2'd1,
      FLD_LAST  = 2'd2
   } win_fld_e;
endpackage

// File: rtl/osd_win_regs.sv
module osd_win_regs
   import osd_win_pkg::*;
#(
   parameter int                  NUM_OVL = 3,
   parameter int                  IDX_W   = 16,
   parameter int                  DATA_W  = 16,
   parameter logic [IDX_W-1:0]    BASE    = 16'h0500
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic [DATA_W-1:0]           wr_data,
   output win_cfg_t [NUM_OVL-1:0]      cfg
);
   localparam int USED_W = LINE_W;

   if (DATA_W < USED_W) begin : g_bad_data
      $error("osd_win_regs: DATA_W must hold a line value");
   end

   line_t wr_val;
   assign wr_val = wr_data[USED_W-1:0];

   for (genvar n = 0; n < NUM_OVL; n++) begin : g_win
      localparam logic [IDX_W-1:0] IDX_POS   = BASE + IDX_W'(FIELDS_PER_WIN*n + int'(FLD_POS));
      localparam logic [IDX_W-1:0] IDX_FIRST = BASE + IDX_W'(FIELDS_PER_WIN*n + int'(FLD_FIRST));
      localparam logic [IDX_W-1:0] IDX_LAST  = BASE + IDX_W'(FIELDS_PER_WIN*n + int'(FLD_LAST));

      logic hit_pos, hit_first, hit_last;
      assign hit_pos   = wr_en && (wr_idx == IDX_POS);
      assign hit_first = wr_en && (wr_idx == IDX_FIRST);
      assign hit_last  = wr_en && (wr_idx == IDX_LAST);

      win_cfg_t cfg_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cfg_q <= '0;
         end else begin
            if (hit_pos)   cfg_q.pos   <= wr_val;
            if (hit_first) cfg_q.first <= wr_val;
            if (hit_last)  cfg_q.last  <= wr_val;
         end
      end

      assign cfg[n] = cfg_q;
   end
endmodule

// File: rtl/osd_line_counter.sv
module osd_line_counter
   import osd_win_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  line_stb,
   input  logic  frame_stb,
   output line_t line_q,
   output line_t line_nxt,
   output logic  upd
);
   always_comb begin
      if (frame_stb)     line_nxt = '0;
      else if (line_stb) line_nxt = line_q + line_t'(1);
      else               line_nxt = line_q;
   end

   assign upd = frame_stb | line_stb;

   always_ff @(posedge clk) begin
      if (!rst_n) line_q <= '0;
      else        line_q <= line_nxt;
   end
endmodule

// File: rtl/osd_win_match.sv
module osd_win_match
   import osd_win_pkg::*;
(
   input  win_cfg_t cfg,
   input  line_t    line,
   output logic     hit,
   output line_t    addr
);
   logic  enabled;
   logic  past_pos;
   line_t span;
   line_t offset;

   always_comb begin
      enabled  = (cfg.last >= cfg.first);
      span     = cfg.last - cfg.first;
      past_pos = (line >= cfg.pos);
      offset   = line - cfg.pos;
      hit      = enabled && past_pos && (offset <= span);
      addr     = cfg.first + offset;
   end
endmodule

// File: rtl/osd_win_select.sv
module osd_win_select
   import osd_win_pkg::*;
#(
   parameter int NUM_OVL = 3,
   parameter int SEL_W   = 2
) (
   input  logic [NUM_OVL-1:0]  hits,
   input  line_t [NUM_OVL-1:0] addrs,
   output logic                any,
   output logic [SEL_W-1:0]    sel,
   output line_t               addr
);
   always_comb begin
      any  = 1'b0;
      sel  = '0;
      addr = '0;
      for (int n = NUM_OVL - 1; n >= 0; n--) begin
         if (hits[n]) begin
            any  = 1'b1;
            sel  = SEL_W'(n);
            addr = addrs[n];
         end
      end
   end
endmodule

// File: rtl/osd_line_addr_gen.sv
module osd_line_addr_gen
   import osd_win_pkg::*;
#(
   parameter int               NUM_OVL        = 3,
   parameter int               IDX_W          = 16,
   parameter int               DATA_W         = 16,
   parameter logic [IDX_W-1:0] BASE_IDX       = 16'h0500,
   parameter int               MODE_W         = 2,
   parameter logic [MODE_W-1:0] INTERLACE_CODE = 2'b11,
   parameter int               SEL_W          = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              line_stb,
   input  logic              frame_stb,
   input  logic [MODE_W-1:0] drive_mode,
   output logic              ovl_active,
   output logic [SEL_W-1:0]  ovl_index,
   output logic [8:0]        ram_line
);
   localparam int NEED_SEL_W = (NUM_OVL > 1) ? $clog2(NUM_OVL) : 1;

   if (NUM_OVL < 1) begin : g_bad_num
      $error("osd_line_addr_gen: NUM_OVL must be at least 1");
   end
   if (SEL_W < NEED_SEL_W) begin : g_bad_sel
      $error("osd_line_addr_gen: SEL_W too narrow for NUM_OVL");
   end
   if (LINE_W != 9) begin : g_bad_line
      $error("osd_line_addr_gen: ram_line port assumes 9-bit lines");
   end

   win_cfg_t [NUM_OVL-1:0] cfg;
   line_t                  line_q;
   line_t                  line_nxt;
   logic                   upd;
   logic [NUM_OVL-1:0]     hits;
   line_t [NUM_OVL-1:0]    addrs;
   logic                   sel_any;
   logic [SEL_W-1:0]       sel_idx;
   line_t                  sel_addr;
   logic                   interlaced;

   osd_win_regs #(
      .NUM_OVL (NUM_OVL),
      .IDX_W   (IDX_W),
      .DATA_W  (DATA_W),
      .BASE    (BASE_IDX)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .cfg     (cfg)
   );

   osd_line_counter u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_stb  (line_stb),
      .frame_stb (frame_stb),
      .line_q    (line_q),
      .line_nxt  (line_nxt),
      .upd       (upd)
   );

   for (genvar n = 0; n < NUM_OVL; n++) begin : g_match
      osd_win_match u_match (
         .cfg  (cfg[n]),
         .line (line_nxt),
         .hit  (hits[n]),
         .addr (addrs[n])
      );
   end

   osd_win_select #(
      .NUM_OVL (NUM_OVL),
      .SEL_W   (SEL_W)
   ) u_sel (
      .hits  (hits),
      .addrs (addrs),
      .any   (sel_any),
      .sel   (sel_idx),
      .addr  (sel_addr)
   );

   assign interlaced = (drive_mode == INTERLACE_CODE);

   always_ff @(posedge clk) begin
      if (!rst_n || interlaced) begin
         ovl_active <= 1'b0;
         ovl_index  <= '0;
         ram_line   <= '0;
      end else if (upd) begin
         ovl_active <= sel_any;
         ovl_index  <= sel_any ? sel_idx : '0;
         ram_line   <= sel_any ? sel_addr : '0;
      end
   end
endmodule

// File: rtl/osd_line_addr_chk.sv
module osd_line_addr_chk
   import osd_win_pkg::*;
#(
   parameter int                NUM_OVL        = 3,
   parameter int                MODE_W         = 2,
   parameter logic [MODE_W-1:0] INTERLACE_CODE = 2'b11,
   parameter int                SEL_W          = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_stb,
   input logic              frame_stb,
   input logic [MODE_W-1:0] drive_mode,
   input logic              ovl_active,
   input logic [SEL_W-1:0]  ovl_index,
   input logic [8:0]        ram_line,
   input line_t             line_q
);
   AST_INTERLACE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(drive_mode == INTERLACE_CODE) |-> !ovl_active); // R8

   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(line_stb) && !$past(frame_stb) && !$past(drive_mode == INTERLACE_CODE))
      |-> $stable({ovl_active, ovl_index, ram_line})); // R9

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !ovl_active |-> (ovl_index == '0 && ram_line == '0)); // R9

   AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ovl_active |-> (int'(ovl_index) < NUM_OVL)); // R6

   AST_FRAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(frame_stb) |-> (line_q == '0)); // R3

   AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(line_stb && !frame_stb) |-> (line_q == line_t'($past(line_q) + line_t'(1)))); // R3
endmodule

bind osd_line_addr_gen osd_line_addr_chk #(
   .NUM_OVL        (NUM_OVL),
   .MODE_W         (MODE_W),
   .INTERLACE_CODE (INTERLACE_CODE),
   .SEL_W          (SEL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_stb   (line_stb),
   .frame_stb  (frame_stb),
   .drive_mode (drive_mode),
   .ovl_active (ovl_active),
   .ovl_index  (ovl_index),
   .ram_line   (ram_line),
   .line_q     (line_q)
);

// File: tb/tb_osd_line_addr_gen.sv
module tb_osd_line_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_idx = '0;
   logic [15:0] wr_data = '0;
   logic        line_stb = 1'b0;
   logic        frame_stb = 1'b0;
   logic [1:0]  drive_mode = 2'b00;
   logic        ovl_active;
   logic [1:0]  ovl_index;
   logic [8:0]  ram_line;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   int m_pos [3];
   int m_first [3];
   int m_last [3];
   int cur_line = 0;

   always #5 clk = ~clk;

   osd_line_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .line_stb(line_stb), .frame_stb(frame_stb), .drive_mode(drive_mode),
      .ovl_active(ovl_active), .ovl_index(ovl_index), .ram_line(ram_line)
   );

   // probe vectors for window set A: {line[20:12], act[11], idx[10:9], addr[8:0]}
   localparam logic [20:0] VEC [12] = '{
      {9'd0,  1'b0, 2'd0, 9'd0},
      {9'd9,  1'b0, 2'd0, 9'd0},
      {9'd10, 1'b1, 2'd0, 9'd100},
      {9'd14, 1'b1, 2'd0, 9'd104},
      {9'd15, 1'b0, 2'd0, 9'd0},
      {9'd19, 1'b0, 2'd0, 9'd0},
      {9'd20, 1'b1, 2'd1, 9'd500},
      {9'd31, 1'b1, 2'd1, 9'd511},
      {9'd32, 1'b0, 2'd0, 9'd0},
      {9'd40, 1'b1, 2'd2, 9'd0},
      {9'd42, 1'b1, 2'd2, 9'd2},
      {9'd43, 1'b0, 2'd0, 9'd0}
   };

   task automatic check(string req, logic eact, logic [1:0] eidx, logic [8:0] eaddr);
      checks++;
      if (ovl_active !== eact || ovl_index !== eidx || ram_line !== eaddr) begin
         errors++;
         $display("FAIL %s line %0d: got act=%0b idx=%0d addr=%0d, expected act=%0b idx=%0d addr=%0d",
                  req, cur_line, ovl_active, ovl_index, ram_line, eact, eidx, eaddr);
      end
   endtask

   task automatic wr(logic [15:0] idx, logic [15:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_win(int n, int p, int s, int e);
      wr(16'h0500 + 16'(3*n),     16'(p));
      wr(16'h0501 + 16'(3*n),     16'(s));
      wr(16'h0502 + 16'(3*n),     16'(e));
      m_pos[n] = p; m_first[n] = s; m_last[n] = e;
   endtask

   task automatic strobe(bit frm, bit ln);
      @(negedge clk);
      frame_stb = frm; line_stb = ln;
      @(negedge clk);
      frame_stb = 1'b0; line_stb = 1'b0;
      if (frm) cur_line = 0;
      else if (ln) cur_line = (cur_line + 1) % 512;
   endtask

   task automatic model(int line, output logic act, output logic [1:0] idx, output logic [8:0] addr);
      act = 1'b0; idx = '0; addr = '0;
      for (int n = 2; n >= 0; n--) begin
         if (m_last[n] >= m_first[n] && line >= m_pos[n] && (line - m_pos[n]) <= (m_last[n] - m_first[n])) begin
            act = 1'b1; idx = 2'(n); addr = 9'((m_first[n] + line - m_pos[n]) % 512);
         end
      end
   endtask

   task automatic scan(string req, int n_lines);
      logic a; logic [1:0] i; logic [8:0] d;
      strobe(1'b1, 1'b0);
      model(cur_line, a, i, d);
      check(req, a, i, d);
      for (int k = 1; k < n_lines; k++) begin
         strobe(1'b0, 1'b1);
         model(cur_line, a, i, d);
         check(req, a, i, d);
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      logic a; logic [1:0] i; logic [8:0] d;
      for (int n = 0; n < 3; n++) begin m_pos[n] = 0; m_first[n] = 0; m_last[n] = 0; end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 reset outputs", 1'b0, 2'd0, 9'd0);
      // R2/R4: cleared settings make overlay 0 cover only line 0 at RAM line 0
      strobe(1'b1, 1'b0);
      check("R2 R4 zero settings line0", 1'b1, 2'd0, 9'd0);
      strobe(1'b0, 1'b1);
      check("R2 R4 zero settings line1", 1'b0, 2'd0, 9'd0);

      // set A, probe table (R1 R4 R5)
      set_win(0, 10, 100, 104);
      set_win(1, 20, 500, 511);
      set_win(2, 40, 0, 2);
      strobe(1'b1, 1'b0);
      for (int v = 0; v < 12; v++) begin
         while (cur_line < int'(VEC[v][20:12])) strobe(1'b0, 1'b1);
         check("R1 R4 R5 probe", VEC[v][11], VEC[v][10:9], VEC[v][8:0]);
      end

      // R9 hold without strobes
      strobe(1'b1, 1'b0);
      repeat (10) strobe(1'b0, 1'b1);
      repeat (4) @(negedge clk);
      check("R9 hold", 1'b1, 2'd0, 9'd100);

      // R3 frame wins over line strobe
      strobe(1'b0, 1'b1); strobe(1'b0, 1'b1);
      strobe(1'b1, 1'b1);
      check("R3 frame wins", 1'b0, 2'd0, 9'd0);
      repeat (10) strobe(1'b0, 1'b1);
      check("R3 count after restart", 1'b1, 2'd0, 9'd100);

      // R8 interlaced disable
      @(negedge clk); drive_mode = 2'b11;
      @(negedge clk);
      check("R8 forced low", 1'b0, 2'd0, 9'd0);
      strobe(1'b0, 1'b1);
      check("R8 strobe ignored", 1'b0, 2'd0, 9'd0);
      @(negedge clk); drive_mode = 2'b01;
      @(negedge clk);
      check("R8 stays zero until strobe", 1'b0, 2'd0, 9'd0);
      strobe(1'b0, 1'b1);
      check("R8 R3 resumes counted line", 1'b1, 2'd0, 9'd102);
      @(negedge clk); drive_mode = 2'b00;

      // R1 ignored indices and high data bits
      wr(16'h0509, 16'h0005);
      wr(16'h04FF, 16'h0007);
      wr(16'h0500, 16'hFE0A);
      scan("R1 decode", 48);

      // R6 overlap priority
      set_win(0, 30, 0, 9);
      set_win(1, 35, 200, 219);
      set_win(2, 30, 300, 300);
      strobe(1'b1, 1'b0);
      repeat (30) strobe(1'b0, 1'b1);
      check("R6 lowest wins at 30", 1'b1, 2'd0, 9'd0);
      repeat (9) strobe(1'b0, 1'b1);
      check("R6 lowest wins at 39", 1'b1, 2'd0, 9'd9);
      strobe(1'b0, 1'b1);
      check("R6 next overlay at 40", 1'b1, 2'd1, 9'd205);
      scan("R6 scan", 60);

      // R7 inverted range, window near counter wrap, full frame plus wrap
      set_win(0, 0, 5, 4);
      set_win(1, 0, 7, 7);
      set_win(2, 500, 0, 20);
      scan("R7 R4 full frame", 512);
      check("R7 line511", 1'b1, 2'd2, 9'd11);
      strobe(1'b0, 1'b1);
      model(cur_line, a, i, d);
      check("R3 wrap to line0", a, i, d);
      check("R7 disabled overlay skipped", 1'b1, 2'd1, 9'd7);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule